// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block produces the fetch address for a small processor whose instructions are 14 bits wide and whose program space is reached through an 11-bit address. Program memory is assumed to return each word one cycle after its address is presented. Because of that delay, the instruction being executed is always the one fetched on the previous cycle, so `pc_o` already points one word past it.

Each cycle the block examines the executing word on `instr_i`, together with a skip request and a write port for the low address byte. From these it picks the next fetch address. The options are a plain increment, a jump target, a call target (which also pushes a return address), or the top of a four-entry circular return stack.

Every change of flow costs one cycle. The word already fetched behind a jump, call, return, low-byte write or taken skip is flushed, and `bubble_o` marks that flushed cycle. During a return, the block also hands the instruction's 8-bit immediate to the accumulator through `ret_ld_o` and `ret_val_o`.

Top module: `pc_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pc_o` is 7FFh and `bubble_o` is 1. At the next clock edge `pc_o` becomes 000h and `bubble_o` becomes 0.
- R2: In a cycle where the executing word is valid and none of the other rules apply, `pc_o` increments by one, wrapping from 7FFh to 000h, and `bubble_o` is 0 in the following cycle.
- R3: A valid word with bits [13:11] = 101 is a jump. In the next cycle `pc_o` equals bits [10:0] of that word and `bubble_o` is 1.
- R4: A valid word with bits [13:11] = 100 is a call. In the next cycle `pc_o` equals bits [10:0] of that word and `bubble_o` is 1. The value `pc_o` had during the call cycle is pushed as the return address.
- R5: A valid word with bits [13:8] = 001100 is a return. In that same cycle `ret_ld_o` is 1 and `ret_val_o` carries bits [7:0]. In the next cycle `pc_o` equals the most recently pushed return address, that entry is popped, and `bubble_o` is 1.
- R6: In a cycle where `bubble_o` is 1, the executing word, `skip_req_i` and `pcl_we_i` are all ignored and `ret_ld_o` is 0. `pc_o` increments by one, and `bubble_o` is 0 in the next cycle.
- R7: With `skip_req_i` high in a valid, non-control cycle, `pc_o` increments by one and the next cycle has `bubble_o` = 1, so the word after the skipping instruction is executed as a no-op.
- R8: With `pcl_we_i` high in a valid, non-control cycle, the next `pc_o` takes `pcl_wdata_i` in bits [7:0] and keeps its current bits [10:8]. `bubble_o` is 1 in the next cycle.
- R9: Priority order, highest first: jump, call or return; then the low-byte write; then the skip request.
- R10: The stack holds four return addresses and is circular. After five nested calls, five returns yield the fifth, fourth, third and second return addresses and then the fifth again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 14 | Instruction word executing this cycle |
| skip_req_i | input | 1 | Condition of the executing skip instruction holds |
| pcl_we_i | input | 1 | Write to the low address byte through the register port |
| pcl_wdata_i | input | 8 | Data for the low address byte write |
| pc_o | output | 11 | Fetch address |
| bubble_o | output | 1 | Executing word is flushed and acts as a no-op |
| ret_ld_o | output | 1 | Return executing: load the immediate into the accumulator |
| ret_val_o | output | 8 | Immediate carried by the return |

## Verification
The case hardest to reach from the ports is stack wrap-around. It only appears after five nested calls without a matching return, followed by more returns than the stack can hold. The stimulus records `pc_o` at each of five calls, lets each call's bubble cycle pass, and then issues five returns. The fifth return must land on the newest address again.

The bench also drives jumps, returns, skips and low-byte writes during bubble cycles, to show that none of them has any effect there.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_JUMP = 2'd1,
        BR_CALL = 2'd2,
        BR_RET  = 2'd3
    } br_kind_e;
endpackage

// File: rtl/pc_seq_dec.sv
module pc_seq_dec
    import pc_seq_pkg::*;
(
    input  logic [5:0] op_i,
    output br_kind_e   kind_o
);
    always_comb begin
        kind_o = BR_NONE;
        if (op_i[5:3] == 3'b101)      kind_o = BR_JUMP;
        else if (op_i[5:3] == 3'b100) kind_o = BR_CALL;
        else if (op_i == 6'b001100)   kind_o = BR_RET;
    end
endmodule

// File: rtl/pc_seq_stack.sv
module pc_seq_stack #(
    parameter int AW    = 11,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_val_i,
    output logic [AW-1:0] top_o
);
    // DEPTH must be a power of two so that the pointer wraps naturally
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] slot;
        logic [PW-1:0]            sp;
    } stk_t;

    stk_t st_d, st_q;
    logic [PW-1:0] rd_idx;

    always_comb begin
        rd_idx = st_q.sp - PW'(1);
        top_o  = st_q.slot[rd_idx];
        st_d   = st_q;
        if (push_i) begin
            st_d.slot[st_q.sp] = push_val_i;
            st_d.sp            = st_q.sp + PW'(1);
        end else if (pop_i) begin
            st_d.sp = rd_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
    import pc_seq_pkg::*;
#(
    parameter int IW    = 14,
    parameter int AW    = 11,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] instr_i,
    input  logic          skip_req_i,
    input  logic          pcl_we_i,
    input  logic [7:0]    pcl_wdata_i,
    output logic [AW-1:0] pc_o,
    output logic          bubble_o,
    output logic          ret_ld_o,
    output logic [7:0]    ret_val_o
);
    localparam int HI = AW - 8;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          bub;
    } seq_t;

    seq_t          st_d, st_q;
    br_kind_e      kind;
    logic          push, pop;
    logic [AW-1:0] stk_top;

    pc_seq_dec u_dec (
        .op_i   (instr_i[IW-1 -: 6]),
        .kind_o (kind)
    );

    pc_seq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .push_val_i (st_q.pc),
        .top_o      (stk_top)
    );

    always_comb begin
        st_d      = st_q;
        push      = 1'b0;
        pop       = 1'b0;
        ret_ld_o  = 1'b0;
        ret_val_o = instr_i[7:0];
        if (st_q.bub) begin
            st_d.pc  = st_q.pc + AW'(1);
            st_d.bub = 1'b0;
        end else begin
            unique case (kind)
                BR_JUMP: begin
                    st_d.pc  = instr_i[AW-1:0];
                    st_d.bub = 1'b1;
                end
                BR_CALL: begin
                    push     = 1'b1;
                    st_d.pc  = instr_i[AW-1:0];
                    st_d.bub = 1'b1;
                end
                BR_RET: begin
                    pop      = 1'b1;
                    ret_ld_o = 1'b1;
                    st_d.pc  = stk_top;
                    st_d.bub = 1'b1;
                end
                default: begin
                    if (pcl_we_i) begin
                        st_d.pc  = {st_q.pc[AW-1 -: HI], pcl_wdata_i};
                        st_d.bub = 1'b1;
                    end else begin
                        st_d.pc  = st_q.pc + AW'(1);
                        st_d.bub = skip_req_i;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc  <= '1;
            st_q.bub <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o     = st_q.pc;
    assign bubble_o = st_q.bub;
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
    parameter int IW = 14,
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [IW-1:0] instr_i,
    input logic          skip_req_i,
    input logic          pcl_we_i,
    input logic [7:0]    pcl_wdata_i,
    input logic [AW-1:0] pc_o,
    input logic          bubble_o,
    input logic          ret_ld_o,
    input logic [7:0]    ret_val_o
);
    logic is_jc, is_ret, quiet;
    assign is_jc  = (instr_i[IW-1 -: 2] == 2'b10);
    assign is_ret = (instr_i[IW-1 -: 6] == 6'b001100);
    assign quiet  = !bubble_o && !is_jc && !is_ret && !pcl_we_i;

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble_o && is_jc) |=> (bubble_o && pc_o == $past(instr_i[AW-1:0]))); // R3

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !skip_req_i) |=> (!bubble_o && pc_o == AW'($past(pc_o) + AW'(1)))); // R2

    AST_BUBBLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |=> (!bubble_o && pc_o == AW'($past(pc_o) + AW'(1)))); // R6

    AST_BUBBLE_NO_RET: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |-> !ret_ld_o); // R6

    AST_RET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble_o && is_ret) |=> (bubble_o && $past(ret_ld_o) && $past(ret_val_o) == $past(instr_i[7:0]))); // R5

    AST_SKIP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && skip_req_i) |=> (bubble_o && pc_o == AW'($past(pc_o) + AW'(1)))); // R7

    AST_PCL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble_o && pcl_we_i && !is_jc && !is_ret) |=>
        (bubble_o && pc_o[7:0] == $past(pcl_wdata_i) && pc_o[AW-1:8] == $past(pc_o[AW-1:8]))); // R8
endmodule

bind pc_seq pc_seq_chk #(.IW(IW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_i     (instr_i),
    .skip_req_i  (skip_req_i),
    .pcl_we_i    (pcl_we_i),
    .pcl_wdata_i (pcl_wdata_i),
    .pc_o        (pc_o),
    .bubble_o    (bubble_o),
    .ret_ld_o    (ret_ld_o),
    .ret_val_o   (ret_val_o)
);

// File: tb/pc_seq_test.sv
module pc_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] instr = '0;
    logic        skip = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  wd = '0;
    logic [10:0] pc;
    logic        bub, rld;
    logic [7:0]  rval;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pc_seq uut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .skip_req_i(skip),
        .pcl_we_i(we), .pcl_wdata_i(wd), .pc_o(pc), .bubble_o(bub),
        .ret_ld_o(rld), .ret_val_o(rval)
    );

    function automatic logic [13:0] jmp(input logic [10:0] a); return {3'b101, a}; endfunction
    function automatic logic [13:0] cal(input logic [10:0] a); return {3'b100, a}; endfunction
    function automatic logic [13:0] ret(input logic [7:0] i);  return {6'b001100, i}; endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [13:0] i, input logic s, input logic w, input logic [7:0] d);
        instr = i; skip = s; we = w; wd = d;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk("R1 pc in reset", pc, 11'h7FF);
        chk("R1 bubble in reset", bub, 1);
        rst_n = 1'b1;
        chk("R1 pc after release", pc, 11'h7FF);
        tick();
        chk("R1 pc first step", pc, 11'h000);
        chk("R1 bubble cleared", bub, 0);
    endtask

    task automatic t_seq();
        logic [10:0] p;
        for (int k = 0; k < 3; k++) begin
            p = pc; drive(14'h0000, 0, 0, 0); tick();
            chk("R2 increment", pc, p + 11'd1);
            chk("R2 no bubble", bub, 0);
        end
        drive(jmp(11'h7FE), 0, 0, 0); tick();
        drive(14'h0000, 0, 0, 0); tick();
        chk("R2 pre-wrap", pc, 11'h7FF);
        tick();
        chk("R2 wrap to zero", pc, 11'h000);
        chk("R2 wrap no bubble", bub, 0);
    endtask

    task automatic t_jump();
        drive(jmp(11'h123), 0, 0, 0); tick();
        chk("R3 jump target", pc, 11'h123);
        chk("R3 jump bubble", bub, 1);
        drive(jmp(11'h055), 1, 1, 8'h77); tick();
        chk("R6 jump ignored in bubble", pc, 11'h124);
        chk("R6 bubble clears", bub, 0);
    endtask

    task automatic t_skip();
        logic [10:0] p;
        p = pc; drive(14'h0000, 1, 0, 0); tick();
        chk("R7 skip pc", pc, p + 11'd1);
        chk("R7 skip bubble", bub, 1);
        drive(14'h0000, 1, 0, 0); tick();
        chk("R6 skip ignored pc", pc, p + 11'd2);
        chk("R6 skip ignored bubble", bub, 0);
    endtask

    task automatic t_pcl();
        logic [10:0] p;
        p = pc; drive(14'h0000, 0, 1, 8'h3C); tick();
        chk("R8 low byte write", pc, {p[10:8], 8'h3C});
        chk("R8 write bubble", bub, 1);
        drive(14'h0000, 0, 1, 8'hAA); tick();
        chk("R6 write ignored", pc, {p[10:8], 8'h3D});
    endtask

    task automatic t_callret();
        drive(jmp(11'h140), 0, 0, 0); tick();
        drive(14'h0000, 0, 0, 0); tick();
        chk("R3 setup", pc, 11'h141);
        drive(cal(11'h200), 0, 0, 0); tick();
        chk("R4 call target", pc, 11'h200);
        chk("R4 call bubble", bub, 1);
        drive(ret(8'h77), 0, 0, 0); #1;
        chk("R6 no acc load in bubble", rld, 0);
        tick();
        chk("R6 return ignored", pc, 11'h201);
        drive(14'h0000, 0, 0, 0); tick();
        drive(ret(8'h5A), 0, 0, 0); #1;
        chk("R5 acc load", rld, 1);
        chk("R5 acc value", rval, 8'h5A);
        tick();
        chk("R4 return address", pc, 11'h141);
        chk("R5 return bubble", bub, 1);
        drive(14'h0000, 0, 0, 0); tick();
        chk("R5 after return", pc, 11'h142);
    endtask

    task automatic t_prio();
        drive(jmp(11'h333), 1, 1, 8'h11); tick();
        chk("R9 jump beats write", pc, 11'h333);
        drive(14'h0000, 0, 0, 0); tick();
        drive(14'h0000, 1, 1, 8'h99); tick();
        chk("R9 write beats skip", pc, 11'h399);
        chk("R9 bubble", bub, 1);
        drive(14'h0000, 0, 0, 0); tick();
        chk("R9 after", pc, 11'h39A);
    endtask

    task automatic t_depth();
        logic [10:0] ra [5];
        logic [10:0] exp_seq [5];
        for (int k = 0; k < 5; k++) begin
            ra[k] = pc;
            drive(cal(11'h400 + 11'(k * 16)), 0, 0, 0); tick();
            chk("R10 nested call", pc, 11'h400 + 11'(k * 16));
            drive(14'h0000, 0, 0, 0); tick();
        end
        exp_seq[0] = ra[4]; exp_seq[1] = ra[3]; exp_seq[2] = ra[2];
        exp_seq[3] = ra[1]; exp_seq[4] = ra[4];
        for (int k = 0; k < 5; k++) begin
            drive(ret(8'h00), 0, 0, 0); tick();
            chk("R10 circular pop", pc, exp_seq[k]);
            drive(14'h0000, 0, 0, 0); tick();
        end
    endtask

    initial begin
        t_reset();
        t_seq();
        t_jump();
        t_skip();
        t_pcl();
        t_callret();
        t_prio();
        t_depth();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog R1..: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule